// File: doc/BRIEF.md
# Round-Robin Shared Transaction Engine

Three independent requester processes share one send/receive engine that talks to a single peer. A requester holds its packet on its data lane and raises its valid line. A round-robin arbiter picks one requester while the engine is free, records the winner's index as a tag, and moves the packet to the peer port. The engine then waits for the peer's answer. The wait is bounded by a cycle counter that is loaded when the request is accepted.

When the answer arrives, or the counter runs out, the engine raises a one-cycle completion pulse on the done line of the tagged requester only. The pulse carries either the response word or a timeout flag. Only one exchange is in flight at a time. A requester that stalls, or a peer that never answers, holds the engine for a bounded number of cycles and cannot block the others.

Top module: `rr_xact_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_grant`, `done`, `done_timeout` and `tx_valid` are all zero. The round-robin pointer starts at requester 0.
- R2: `req_grant` is at most one-hot. It pulses for exactly one cycle, in the cycle after the accepting edge, for a requester whose `req_valid` was high at that edge. A requester keeps `req_valid` high until it sees its grant.
- R3: Priority starts at the requester just after the most recently granted one and scans upward modulo 3. With requesters 0, 1 and 2 valid at once after reset, the grant order is 0, 1, 2.
- R4: From the cycle after acceptance, `tx_valid` is high with `tx_data` equal to the accepted packet and `tx_tag` equal to the requester index. Both are held stable until a cycle in which `tx_ready` is high.
- R5: A response accepted while waiting produces exactly one one-cycle pulse on `done` at bit position equal to the tag. In that cycle `done_data` equals `rsp_data` and `done_timeout` is 0. The pulse appears in the cycle after the edge that sampled `rsp_valid`.
- R6: If the transaction has not ended after TMO_CYCLES cycles in the send and wait phases, the engine completes it anyway. In that completion `done_timeout` is 1 and `done_data` is 0. This also applies when `tx_ready` never arrives.
- R7: Only one exchange is in flight. No grant is issued between a grant and its completion. A `rsp_valid` that arrives when no response is awaited produces no `done` pulse.
- R8: If `rsp_valid` arrives in the same cycle that the timeout expires, the response wins and `done_timeout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_data | input | N_REQ*DATA_W | Request packets; requester i uses bits [i*DATA_W +: DATA_W] |
| req_grant | output | N_REQ | One-cycle acceptance pulse, one-hot |
| tx_valid | output | 1 | Packet offered to the peer |
| tx_data | output | DATA_W | Packet word to the peer |
| tx_tag | output | TAG_W | Index of the owning requester |
| tx_ready | input | 1 | Peer takes the packet |
| rsp_valid | input | 1 | Peer answer valid |
| rsp_data | input | DATA_W | Peer answer word |
| done | output | N_REQ | One-cycle completion pulse, bit = owning requester |
| done_data | output | DATA_W | Response word for the completion (0 on timeout) |
| done_timeout | output | 1 | Completion ended by timeout |

## Verification
A corrupted tag or pointer shows up directly at the ports. The completion pulse lands on the wrong requester's bit, or the grant order breaks the rotation, at the next grant or done pulse. A faulty timer shows up as a completion one cycle early or late against a peer that answers exactly at the deadline, or answers one cycle too late. A wrong phase in the state machine shows up as a second grant before a completion, or as a done pulse caused by a stray response, within a few cycles of the event.

// File: rtl/rr_xe_pkg.sv
package rr_xe_pkg;

  typedef enum logic [1:0] {
    XE_IDLE = 2'd0,
    XE_SEND = 2'd1,
    XE_WAIT = 2'd2,
    XE_RESP = 2'd3
  } xe_state_e;

  // modulo wrap for the rotating pointer
  function automatic int rr_wrap(input int value, input int modulus);
    return value % modulus;
  endfunction

  // one-hot from an index
  function automatic logic [31:0] rr_onehot(input int index);
    return 32'd1 << index;
  endfunction

endpackage

// File: rtl/rr_xe_arbiter.sv
module rr_xe_arbiter #(
  parameter int N_REQ = 3,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             advance,
  output logic             any_req,
  output logic [TAG_W-1:0] win_idx
);
  import rr_xe_pkg::*;

  logic [TAG_W-1:0] ptr_q;

  // scan from the pointer upward; the lowest offset is written last and wins
  always_comb begin
    any_req = 1'b0;
    win_idx = ptr_q;
    for (int off = N_REQ - 1; off >= 0; off--) begin
      int cand;
      cand = rr_wrap(int'(ptr_q) + off, N_REQ);
      if (req[cand]) begin
        any_req = 1'b1;
        win_idx = TAG_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= TAG_W'(rr_wrap(int'(win_idx) + 1, N_REQ));
    end
  end

endmodule

// File: rtl/rr_xe_timer.sv
module rr_xe_timer #(
  parameter int TMO_CYCLES = 64,
  parameter int CNT_W      = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(TMO_CYCLES - 1);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rr_xe_ctrl.sv
module rr_xe_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  any_req,
  input  logic                  tx_ready,
  input  logic                  rsp_valid,
  input  logic                  tmo_expire,
  output rr_xe_pkg::xe_state_e  state,
  output logic                  accept,
  output logic                  fin_rsp,
  output logic                  fin_tmo,
  output logic                  busy
);
  import rr_xe_pkg::*;

  xe_state_e state_q, state_d;

  assign state = state_q;
  assign busy  = (state_q == XE_SEND) || (state_q == XE_WAIT);

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    fin_rsp = 1'b0;
    fin_tmo = 1'b0;
    unique case (state_q)
      XE_IDLE: if (any_req) begin
        accept  = 1'b1;
        state_d = XE_SEND;
      end
      XE_SEND: if (tmo_expire) begin
        fin_tmo = 1'b1;
        state_d = XE_RESP;
      end else if (tx_ready) begin
        state_d = XE_WAIT;
      end
      XE_WAIT: if (rsp_valid) begin
        fin_rsp = 1'b1;
        state_d = XE_RESP;
      end else if (tmo_expire) begin
        fin_tmo = 1'b1;
        state_d = XE_RESP;
      end
      XE_RESP: state_d = XE_IDLE;
      default: state_d = XE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= XE_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/rr_xact_engine.sv
module rr_xact_engine #(
  parameter int N_REQ      = 3,
  parameter int DATA_W     = 16,
  parameter int TMO_CYCLES = 64,
  localparam int TAG_W     = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int CNT_W     = $clog2(TMO_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [N_REQ*DATA_W-1:0] req_data,
  output logic [N_REQ-1:0]        req_grant,
  output logic                    tx_valid,
  output logic [DATA_W-1:0]       tx_data,
  output logic [TAG_W-1:0]        tx_tag,
  input  logic                    tx_ready,
  input  logic                    rsp_valid,
  input  logic [DATA_W-1:0]       rsp_data,
  output logic [N_REQ-1:0]        done,
  output logic [DATA_W-1:0]       done_data,
  output logic                    done_timeout
);
  import rr_xe_pkg::*;

  // named internal events, visible to the bound checker
  logic             any_req;
  logic [TAG_W-1:0] win_idx;
  logic             accept;
  logic             fin_rsp;
  logic             fin_tmo;
  logic             xact_busy;
  logic             tmo_expire;
  logic             eng_idle;
  logic             xact_wait;
  xe_state_e        state;

  logic [N_REQ-1:0]  grant_q;
  logic [DATA_W-1:0] pkt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] rsp_q;
  logic              tmo_q;

  rr_xe_arbiter #(.N_REQ(N_REQ), .TAG_W(TAG_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .advance (accept),
    .any_req (any_req),
    .win_idx (win_idx)
  );

  rr_xe_timer #(.TMO_CYCLES(TMO_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (xact_busy),
    .expire (tmo_expire)
  );

  rr_xe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .tx_ready   (tx_ready),
    .rsp_valid  (rsp_valid),
    .tmo_expire (tmo_expire),
    .state      (state),
    .accept     (accept),
    .fin_rsp    (fin_rsp),
    .fin_tmo    (fin_tmo),
    .busy       (xact_busy)
  );

  assign eng_idle  = (state == XE_IDLE);
  assign xact_wait = (state == XE_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      pkt_q   <= '0;
      tag_q   <= '0;
      rsp_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      grant_q <= accept ? N_REQ'(rr_onehot(int'(win_idx))) : '0;
      if (accept) begin
        pkt_q <= req_data[int'(win_idx)*DATA_W +: DATA_W];
        tag_q <= win_idx;
      end
      if (fin_rsp) begin
        rsp_q <= rsp_data;
        tmo_q <= 1'b0;
      end else if (fin_tmo) begin
        rsp_q <= '0;
        tmo_q <= 1'b1;
      end
    end
  end

  assign req_grant    = grant_q;
  assign tx_valid     = (state == XE_SEND);
  assign tx_data      = pkt_q;
  assign tx_tag       = tag_q;
  assign done         = (state == XE_RESP) ? N_REQ'(rr_onehot(int'(tag_q))) : '0;
  assign done_data    = rsp_q;
  assign done_timeout = (state == XE_RESP) && tmo_q;

endmodule

// File: rtl/rr_xe_checker.sv
module rr_xe_checker #(
  parameter int N_REQ      = 3,
  parameter int DATA_W     = 16,
  parameter int TMO_CYCLES = 64,
  parameter int TAG_W      = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ-1:0]        req_grant,
  input logic                    tx_valid,
  input logic [DATA_W-1:0]       tx_data,
  input logic [TAG_W-1:0]        tx_tag,
  input logic                    tx_ready,
  input logic                    rsp_valid,
  input logic [N_REQ-1:0]        done,
  input logic [DATA_W-1:0]       done_data,
  input logic                    done_timeout,
  input logic                    xact_busy,
  input logic                    eng_idle,
  input logic                    xact_wait
);
  logic [31:0]      busy_cnt;
  logic [N_REQ-1:0] owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      owner_q  <= '0;
    end else begin
      busy_cnt <= xact_busy ? busy_cnt + 1 : '0;
      if (|req_grant) owner_q <= req_grant;
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));

  p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |req_grant |-> ((req_grant & ~$past(req_valid)) == '0));

  p_single_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |req_grant |-> $past(eng_idle));

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && xact_busy) |=> (!tx_valid || ($stable(tx_data) && $stable(tx_tag))));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |done |=> (done == '0));

  p_done_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |done |-> (done == owner_q));

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xact_busy |-> (busy_cnt < 32'(TMO_CYCLES)));

  p_tmo_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout |-> ((|done) && done_data == '0));

  p_rsp_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_wait && rsp_valid) |=> ((|done) && !done_timeout));

endmodule

bind rr_xact_engine rr_xe_checker #(
  .N_REQ(N_REQ), .DATA_W(DATA_W), .TMO_CYCLES(TMO_CYCLES), .TAG_W(TAG_W)
) u_rr_xe_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_grant    (req_grant),
  .tx_valid     (tx_valid),
  .tx_data      (tx_data),
  .tx_tag       (tx_tag),
  .tx_ready     (tx_ready),
  .rsp_valid    (rsp_valid),
  .done         (done),
  .done_data    (done_data),
  .done_timeout (done_timeout),
  .xact_busy    (xact_busy),
  .eng_idle     (eng_idle),
  .xact_wait    (xact_wait)
);

// File: tb/test_rr_xact_engine.sv
module test_rr_xact_engine;
  localparam int N  = 3;
  localparam int DW = 16;
  localparam int T  = 8;
  localparam int TW = 2;
  localparam logic [DW-1:0] RSP_KEY = 16'hC3C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]  req_grant;
  logic          tx_valid;
  logic [DW-1:0] tx_data;
  logic [TW-1:0] tx_tag;
  logic          tx_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [N-1:0]  done;
  logic [DW-1:0] done_data;
  logic          done_timeout;

  int checks = 0;
  int failures = 0;
  int in_flight = 0;
  bit finished = 0;

  // peer behaviour: 0 = answer after peer_delay, 1 = take but never answer, 2 = never take
  int peer_mode = 0;
  int peer_delay = 2;

  logic [DW-1:0] last_data [N];
  int            exp_grant_q[$];
  int            sb_idx[$];
  logic [DW-1:0] sb_data[$];
  bit            sb_tmo[$];

  always #10 clk = ~clk;

  rr_xact_engine #(.N_REQ(N), .DATA_W(DW), .TMO_CYCLES(T)) i_rr_xact_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_grant(req_grant), .tx_valid(tx_valid), .tx_data(tx_data), .tx_tag(tx_tag),
    .tx_ready(tx_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .done_data(done_data), .done_timeout(done_timeout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one requester raises its packet and holds it until granted
  task automatic request(input int idx, input logic [DW-1:0] data, input bit exp_tmo);
    @(negedge clk);
    last_data[idx] = data;
    req_data[idx*DW +: DW] = data;
    req_valid[idx] = 1'b1;
    do @(negedge clk); while (!req_grant[idx]);
    req_valid[idx] = 1'b0;
    sb_idx.push_back(idx);
    sb_data.push_back(exp_tmo ? '0 : (data ^ RSP_KEY));
    sb_tmo.push_back(exp_tmo);
  endtask

  task automatic settle();
    wait (in_flight == 0);
    repeat (4) @(negedge clk);
  endtask

  // peer model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid) begin
        chk(tx_data == last_data[tx_tag], "R4 tx_data", 32'(tx_data), 32'(last_data[tx_tag]));
        if (peer_mode == 2) begin
          while (tx_valid) @(negedge clk);
        end else begin
          logic [DW-1:0] word;
          word = tx_data ^ RSP_KEY;
          tx_ready = 1'b1;
          @(negedge clk);
          tx_ready = 1'b0;
          chk(!tx_valid, "R4 tx_valid drops after take", 32'(tx_valid), 0);
          if (peer_mode == 0) begin
            repeat (peer_delay - 1) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = word;
            @(negedge clk);
            rsp_valid = 1'b0;
          end
        end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (|req_grant) begin
        chk(in_flight == 0, "R7 grant while busy", 32'(in_flight), 0);
        chk($countones(req_grant) == 1, "R2 grant one-hot", 32'(req_grant), 1);
        if (exp_grant_q.size() == 0) begin
          chk(1'b0, "R3 unexpected grant", 32'(req_grant), 0);
        end else begin
          int g;
          g = exp_grant_q.pop_front();
          chk(req_grant == N'(1 << g), "R3 grant order", 32'(req_grant), 32'(1 << g));
        end
        in_flight++;
      end
      if (|done) begin
        if (sb_idx.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 32'(done), 0);
        end else begin
          int i;
          logic [DW-1:0] d;
          bit t;
          i = sb_idx.pop_front();
          d = sb_data.pop_front();
          t = sb_tmo.pop_front();
          chk(done == N'(1 << i), "R5 done owner", 32'(done), 32'(1 << i));
          chk(done_data == d, t ? "R6 timeout data" : "R5 done data", 32'(done_data), 32'(d));
          chk(done_timeout == t, t ? "R6 timeout flag" : "R8 R5 timeout flag", 32'(done_timeout), 32'(t));
        end
        in_flight--;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_grant == '0 && done == '0, "R1 reset outputs", 32'({req_grant, done}), 0);
    chk(!tx_valid, "R1 tx_valid in reset", 32'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_timeout && req_grant == '0, "R1 after reset", 32'({done_timeout, req_grant}), 0);

    // R3: from reset the pointer is 0 -> order 0,1,2
    peer_mode = 0; peer_delay = 2;
    exp_grant_q = '{0, 1, 2};
    fork
      request(0, 16'h1111, 1'b0);
      request(1, 16'h2222, 1'b0);
      request(2, 16'h3333, 1'b0);
    join
    settle();

    // R5: single requester
    exp_grant_q = '{1};
    request(1, 16'h1234, 1'b0);
    settle();

    // R3: pointer now 2 -> order 2,0,1
    peer_delay = 3;
    exp_grant_q = '{2, 0, 1};
    fork
      request(0, 16'hA0A0, 1'b0);
      request(1, 16'hB1B1, 1'b0);
      request(2, 16'hC2C2, 1'b0);
    join
    settle();

    // R6: peer takes but never answers
    peer_mode = 1;
    exp_grant_q = '{0};
    request(0, 16'h0F0F, 1'b1);
    settle();

    // R8: answer exactly at the deadline wins
    peer_mode = 0; peer_delay = T - 1;
    exp_grant_q = '{2};
    request(2, 16'h5555, 1'b0);
    settle();

    // R6 + R7: answer one cycle late -> timeout, stray answer ignored
    peer_delay = T;
    exp_grant_q = '{2};
    request(2, 16'h6666, 1'b1);
    settle();
    chk(done == '0, "R7 stray response ignored", 32'(done), 0);

    // R6: peer never takes the packet
    peer_mode = 2;
    exp_grant_q = '{1};
    request(1, 16'h7777, 1'b1);
    settle();

    // R3: pointer at 2, requesters 0 and 1 -> 0 then 1
    peer_mode = 0; peer_delay = 2;
    exp_grant_q = '{0, 1};
    fork
      request(1, 16'h8888, 1'b0);
      request(0, 16'h9999, 1'b0);
    join
    settle();

    chk(sb_idx.size() == 0, "R5 all completions seen", 32'(sb_idx.size()), 0);
    chk(exp_grant_q.size() == 0, "R3 all grants seen", 32'(exp_grant_q.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule